// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the sequencing engine of one DMA channel. Once it is armed, it issues single-beat copy requests toward a simple memory port. Each request carries a source address, a destination address and a beat size. The port answers each request with an acknowledge or an error. The amount of work is two nested counts: a number of beats per block and a number of blocks. Each count is programmed as its value minus one. The beat width can be byte, half-word or word. The source address and the destination address are each set separately to step by the beat size or to stay fixed.

Five start modes decide what releases the beats. Two software modes wait for a `sw_trig` pulse. Three hardware modes follow the `hw_req` line. In block modes, one trigger moves one block and the channel then waits for the next trigger. In burst modes, one trigger runs the whole job. In demand mode, beats flow only while `hw_req` stays high. When the job ends, each address can optionally snap back to its programmed start. Two sticky flags report the result. The done flag marks a normal finish. The error flag marks a memory-port error or a forced stop. Each flag has its own enable.

The controller is a five-state machine. IDLE waits for `start`, which latches the configuration and loads the counters and addresses (IDLE→ARMED). ARMED waits for the mode's trigger (ARMED→BEAT). A forced stop moves ARMED→ABORT. BEAT holds one request until the port answers. From BEAT, an acknowledge leads to BEAT→BEAT (the next beat), to BEAT→ARMED (end of block in a block mode, or `hw_req` low in demand mode) or to BEAT→CMPL (last beat). An error response or a forced stop leads to BEAT→ABORT. CMPL applies the address reload and raises the done flag (CMPL→IDLE). ABORT raises the error flag (ABORT→IDLE).

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the channel is idle. `busy`, `mem_req`, `done_flag` and `err_flag` are all low.
- R2: `cfg_width` selects the beat size. Code 0 is byte, 1 is half-word and 2 is word; code 3 acts as word. `mem_size` carries the selected code (0, 1 or 2). Each acknowledged beat advances a stepping address by 1, 2 or 4.
- R3: An address whose fixed bit (`cfg_src_fix` or `cfg_dst_fix`) is set keeps its start value on every beat of the job.
- R4: A job moves exactly (`cfg_blk_m1`+1)×(`cfg_xfer_m1`+1) beats. This holds up to 16 beats per block and 65536 blocks.
- R5: In the block modes (`cfg_mode` 0 = software block, 3 = hardware block), one trigger moves one block of beats. The channel then stays busy, with no request, until the next trigger.
- R6: In the burst modes (`cfg_mode` 1 = software burst, 4 = hardware burst), one trigger runs every beat of the job to completion.
- R7: In demand mode (`cfg_mode` 2), a beat starts or continues only while `hw_req` is high. When `hw_req` falls, the channel waits without losing its position.
- R8: The software modes (0, 1, and the unused codes 5 to 7, which act as mode 0) respond only to `sw_trig`. The hardware modes (2, 3, 4) respond only to `hw_req`; a `sw_trig` pulse in a hardware mode has no effect.
- R9: When a job completes, an address with its reload bit set returns to its programmed start. Without reload, an address stays one step past its last beat. The current addresses are visible on `mem_src` and `mem_dst`.
- R10: A normal finish sets `done_flag` only when `cfg_done_en` is set. `start` clears both flags.
- R11: An error response (`mem_err`) or a `force_stop` while busy ends the job. The errored beat does not count. `err_flag` is set only when `cfg_err_en` is set, and `done_flag` stays low.
- R12: A request holds, with stable addresses, until the port acknowledges it or flags an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_src_addr | input | 32 | Source start address |
| cfg_dst_addr | input | 32 | Destination start address |
| cfg_width | input | 2 | Beat size code |
| cfg_blk_m1 | input | 4 | Beats per block minus one |
| cfg_xfer_m1 | input | 16 | Blocks minus one |
| cfg_src_fix | input | 1 | Hold source address fixed |
| cfg_dst_fix | input | 1 | Hold destination address fixed |
| cfg_src_reload | input | 1 | Restore source address at completion |
| cfg_dst_reload | input | 1 | Restore destination address at completion |
| cfg_mode | input | 3 | Start mode code |
| cfg_done_en | input | 1 | Enable done reporting |
| cfg_err_en | input | 1 | Enable error reporting |
| start | input | 1 | Latch configuration and arm (idle only) |
| sw_trig | input | 1 | Software trigger |
| hw_req | input | 1 | Hardware request |
| force_stop | input | 1 | Abort the running job |
| mem_req | output | 1 | Beat request valid |
| mem_src | output | 32 | Current source address |
| mem_dst | output | 32 | Current destination address |
| mem_size | output | 2 | Beat size code |
| mem_ack | input | 1 | Beat accepted |
| mem_err | input | 1 | Beat failed |
| busy | output | 1 | Job in progress |
| done_flag | output | 1 | Sticky normal completion |
| err_flag | output | 1 | Sticky abnormal completion |

## Verification
The bench checks how the two counts carry into each other across a full 65536-block job. A counter that wrapped or stopped early would end with the wrong beat total and the wrong final address. It also checks that block modes pause between blocks and that demand mode pauses when the request falls. A design that ran through those pauses, or lost its place, would show extra or missing beats. The errored or stopped beat must not be counted and must not raise the done flag. A `sw_trig` pulse in a hardware mode must be ignored; a design that accepted it would start beats. The bench also checks the width code 3 fallback and the difference between reloaded and non-reloaded final addresses.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_BEAT,
        ST_CMPL,
        ST_ABORT
    } seq_state_e;

    localparam logic [2:0] MODE_SW_BLOCK  = 3'd0;
    localparam logic [2:0] MODE_SW_BURST  = 3'd1;
    localparam logic [2:0] MODE_HW_DEMAND = 3'd2;
    localparam logic [2:0] MODE_HW_BLOCK  = 3'd3;
    localparam logic [2:0] MODE_HW_BURST  = 3'd4;

    typedef struct packed {
        logic [1:0] width;
        logic [2:0] mode;
        logic       src_fix;
        logic       dst_fix;
        logic       src_rl;
        logic       dst_rl;
        logic       done_en;
        logic       err_en;
    } chan_cfg_t;

    function automatic logic [2:0] step_bytes(input logic [1:0] w);
        unique case (w)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dmaseq_beat_counter.sv
module dmaseq_beat_counter #(
    parameter int BLK_W  = 4,
    parameter int XFER_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BLK_W-1:0]  blk_init,
    input  logic [XFER_W-1:0] xfer_init,
    input  logic              step,
    output logic              blk_last,
    output logic              all_last
);

    logic [BLK_W-1:0]  blk_q;
    logic [BLK_W-1:0]  blk_rl_q;
    logic [XFER_W-1:0] xfer_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q    <= '0;
            blk_rl_q <= '0;
            xfer_q   <= '0;
        end else if (load) begin
            blk_q    <= blk_init;
            blk_rl_q <= blk_init;
            xfer_q   <= xfer_init;
        end else if (step) begin
            if (blk_q == '0) begin
                blk_q <= blk_rl_q;
                if (xfer_q != '0) begin
                    xfer_q <= xfer_q - 1'b1;
                end
            end else begin
                blk_q <= blk_q - 1'b1;
            end
        end
    end

    assign blk_last = (blk_q == '0);
    assign all_last = blk_last && (xfer_q == '0);

endmodule

// File: rtl/dmaseq_addr_unit.sv
module dmaseq_addr_unit #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] init,
    input  logic          step,
    input  logic          fix,
    input  logic          restore,
    input  logic [2:0]    incr,
    output logic [AW-1:0] cur
);

    logic [AW-1:0] cur_q;
    logic [AW-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            base_q <= '0;
        end else if (load) begin
            cur_q  <= init;
            base_q <= init;
        end else if (restore) begin
            cur_q <= base_q;
        end else if (step && !fix) begin
            cur_q <= cur_q + AW'(incr);
        end
    end

    assign cur = cur_q;

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dmaseq_pkg::*;
#(
    parameter int AW     = 32,
    parameter int BLK_W  = 4,
    parameter int XFER_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     cfg_src_addr,
    input  logic [AW-1:0]     cfg_dst_addr,
    input  logic [1:0]        cfg_width,
    input  logic [BLK_W-1:0]  cfg_blk_m1,
    input  logic [XFER_W-1:0] cfg_xfer_m1,
    input  logic              cfg_src_fix,
    input  logic              cfg_dst_fix,
    input  logic              cfg_src_reload,
    input  logic              cfg_dst_reload,
    input  logic [2:0]        cfg_mode,
    input  logic              cfg_done_en,
    input  logic              cfg_err_en,
    input  logic              start,
    input  logic              sw_trig,
    input  logic              hw_req,
    input  logic              force_stop,
    output logic              mem_req,
    output logic [AW-1:0]     mem_src,
    output logic [AW-1:0]     mem_dst,
    output logic [1:0]        mem_size,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              busy,
    output logic              done_flag,
    output logic              err_flag
);

    localparam int NUM_PTR = 2;

    seq_state_e state_q, state_d;
    chan_cfg_t  cfg_q;

    logic       load;
    logic       beat_step;
    logic       restore_pulse;
    logic       blk_last;
    logic       all_last;
    logic       is_hw;
    logic       is_block;
    logic       is_demand;
    logic       trig;
    logic [2:0] incr;

    // Mode decode; unused codes fall back to software block
    always_comb begin
        is_hw     = 1'b0;
        is_block  = 1'b0;
        is_demand = 1'b0;
        unique case (cfg_q.mode)
            MODE_SW_BURST:  ;
            MODE_HW_DEMAND: begin is_hw = 1'b1; is_demand = 1'b1; end
            MODE_HW_BLOCK:  begin is_hw = 1'b1; is_block  = 1'b1; end
            MODE_HW_BURST:  is_hw = 1'b1;
            default:        is_block = 1'b1;
        endcase
    end

    assign trig = is_hw ? hw_req : sw_trig;
    assign incr = step_bytes(cfg_q.width);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (force_stop)  state_d = ST_ABORT;
                else if (trig)   state_d = ST_BEAT;
            end
            ST_BEAT: begin
                if (force_stop || mem_err) begin
                    state_d = ST_ABORT;
                end else if (mem_ack) begin
                    if (all_last)                   state_d = ST_CMPL;
                    else if (blk_last && is_block)  state_d = ST_ARMED;
                    else if (is_demand && !hw_req)  state_d = ST_ARMED;
                    else                            state_d = ST_BEAT;
                end
            end
            ST_CMPL:  state_d = ST_IDLE;
            ST_ABORT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath strobes
    always_comb begin
        mem_req       = (state_q == ST_BEAT);
        busy          = (state_q != ST_IDLE);
        load          = (state_q == ST_IDLE) && start;
        beat_step     = (state_q == ST_BEAT) && mem_ack && !mem_err && !force_stop;
        restore_pulse = (state_q == ST_CMPL);
        mem_size      = cfg_q.width;
    end

    // Latched configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q.width   <= (cfg_width == 2'd3) ? 2'd2 : cfg_width;
            cfg_q.mode    <= cfg_mode;
            cfg_q.src_fix <= cfg_src_fix;
            cfg_q.dst_fix <= cfg_dst_fix;
            cfg_q.src_rl  <= cfg_src_reload;
            cfg_q.dst_rl  <= cfg_dst_reload;
            cfg_q.done_en <= cfg_done_en;
            cfg_q.err_en  <= cfg_err_en;
        end
    end

    // Completion flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            err_flag  <= 1'b0;
        end else if (load) begin
            done_flag <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            if (state_q == ST_CMPL && cfg_q.done_en)  done_flag <= 1'b1;
            if (state_q == ST_ABORT && cfg_q.err_en)  err_flag  <= 1'b1;
        end
    end

    dmaseq_beat_counter #(
        .BLK_W  (BLK_W),
        .XFER_W (XFER_W)
    ) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .blk_init  (cfg_blk_m1),
        .xfer_init (cfg_xfer_m1),
        .step      (beat_step),
        .blk_last  (blk_last),
        .all_last  (all_last)
    );

    logic [AW-1:0] ptr_init [NUM_PTR];
    logic [AW-1:0] ptr_cur  [NUM_PTR];
    logic          ptr_fix  [NUM_PTR];
    logic          ptr_rl   [NUM_PTR];

    assign ptr_init[0] = cfg_src_addr;
    assign ptr_init[1] = cfg_dst_addr;
    assign ptr_fix[0]  = cfg_q.src_fix;
    assign ptr_fix[1]  = cfg_q.dst_fix;
    assign ptr_rl[0]   = cfg_q.src_rl;
    assign ptr_rl[1]   = cfg_q.dst_rl;

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        dmaseq_addr_unit #(
            .AW (AW)
        ) addr_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load),
            .init    (ptr_init[g]),
            .step    (beat_step),
            .fix     (ptr_fix[g]),
            .restore (restore_pulse && ptr_rl[g]),
            .incr    (incr),
            .cur     (ptr_cur[g])
        );
    end

    assign mem_src = ptr_cur[0];
    assign mem_dst = ptr_cur[1];

endmodule

// File: rtl/dmaseq_checker.sv
module dmaseq_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_err,
    input logic          force_stop,
    input logic [AW-1:0] mem_src,
    input logic [AW-1:0] mem_dst,
    input logic [1:0]    mem_size,
    input logic          done_flag,
    input logic          err_flag,
    input logic          src_fix,
    input logic          done_en
);

    logic [AW-1:0] chk_incr;
    assign chk_incr = (mem_size == 2'd0) ? AW'(1) : (mem_size == 2'd1) ? AW'(2) : AW'(4);

    assert_idle_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    assert_size_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_size != 2'd3);

    assert_src_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_err && !force_stop && !src_fix)
        |=> mem_src == $past(mem_src) + $past(chk_incr));

    assert_fixed_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && src_fix && $past(busy)) |-> $stable(mem_src));

    assert_done_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> done_en);

    assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_flag && err_flag));

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err && !force_stop)
        |=> (mem_req && $stable(mem_src) && $stable(mem_dst)));

endmodule

bind dma_chan_seq dmaseq_checker #(.AW(AW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_err    (mem_err),
    .force_stop (force_stop),
    .mem_src    (mem_src),
    .mem_dst    (mem_dst),
    .mem_size   (mem_size),
    .done_flag  (done_flag),
    .err_flag   (err_flag),
    .src_fix    (cfg_q.src_fix),
    .done_en    (cfg_q.done_en)
);

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] SRC0 = 32'h1000_0000;
    localparam logic [31:0] DST0 = 32'h2000_0000;

    typedef struct packed {
        logic [2:0]  mode;
        logic [1:0]  width;
        logic [3:0]  blk;
        logic [15:0] xfer;
        logic        sfix;
        logic        dfix;
        logic        srl;
        logic        drl;
        logic        den;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 2'd2, 4'd1,  16'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{3'd1, 2'd0, 4'd3,  16'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        '{3'd4, 2'd1, 4'd0,  16'd4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
        '{3'd0, 2'd2, 4'd2,  16'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        '{3'd3, 2'd0, 4'd15, 16'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{3'd2, 2'd1, 4'd1,  16'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{3'd1, 2'd3, 4'd0,  16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_src_addr = SRC0, cfg_dst_addr = DST0;
    logic [1:0]  cfg_width = '0;
    logic [3:0]  cfg_blk_m1 = '0;
    logic [15:0] cfg_xfer_m1 = '0;
    logic        cfg_src_fix = 0, cfg_dst_fix = 0, cfg_src_reload = 0, cfg_dst_reload = 0;
    logic [2:0]  cfg_mode = '0;
    logic        cfg_done_en = 0, cfg_err_en = 0;
    logic        start = 0, sw_trig = 0, hw_req = 0, force_stop = 0;
    logic        mem_req, mem_ack, mem_err, busy, done_flag, err_flag;
    logic [31:0] mem_src, mem_dst;
    logic [1:0]  mem_size;
    logic        ack_on = 1, err_on = 0;

    int checks = 0;
    int errors = 0;
    int beat_cnt = 0;
    int bad_beats = 0;
    logic [31:0] exp_src, exp_dst;
    int          exp_inc;
    logic [1:0]  exp_size;
    logic        mon_sfix, mon_dfix;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_ack = mem_req & ack_on;
    assign mem_err = mem_req & err_on;

    dma_chan_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
        .cfg_width(cfg_width), .cfg_blk_m1(cfg_blk_m1), .cfg_xfer_m1(cfg_xfer_m1),
        .cfg_src_fix(cfg_src_fix), .cfg_dst_fix(cfg_dst_fix),
        .cfg_src_reload(cfg_src_reload), .cfg_dst_reload(cfg_dst_reload),
        .cfg_mode(cfg_mode), .cfg_done_en(cfg_done_en), .cfg_err_en(cfg_err_en),
        .start(start), .sw_trig(sw_trig), .hw_req(hw_req), .force_stop(force_stop),
        .mem_req(mem_req), .mem_src(mem_src), .mem_dst(mem_dst), .mem_size(mem_size),
        .mem_ack(mem_ack), .mem_err(mem_err),
        .busy(busy), .done_flag(done_flag), .err_flag(err_flag)
    );

    // Beat monitor: compares every completed beat with the expected stream
    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ack && !mem_err && !force_stop) begin
            if (mem_src !== exp_src || mem_dst !== exp_dst || mem_size !== exp_size)
                bad_beats = bad_beats + 1;
            if (!mon_sfix) exp_src = exp_src + exp_inc;
            if (!mon_dfix) exp_dst = exp_dst + exp_inc;
            beat_cnt = beat_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input vec_t v, input logic err_en);
        cfg_mode       = v.mode;
        cfg_width      = v.width;
        cfg_blk_m1     = v.blk;
        cfg_xfer_m1    = v.xfer;
        cfg_src_fix    = v.sfix;
        cfg_dst_fix    = v.dfix;
        cfg_src_reload = v.srl;
        cfg_dst_reload = v.drl;
        cfg_done_en    = v.den;
        cfg_err_en     = err_en;
        exp_src   = SRC0;
        exp_dst   = DST0;
        exp_size  = (v.width == 2'd3) ? 2'd2 : v.width;
        exp_inc   = (exp_size == 2'd0) ? 1 : (exp_size == 2'd1) ? 2 : 4;
        mon_sfix  = v.sfix;
        mon_dfix  = v.dfix;
        beat_cnt  = 0;
        bad_beats = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
    endtask

    task automatic wait_idle(input int limit);
        for (int k = 0; k < limit && busy; k++) @(negedge clk);
    endtask

    task automatic wait_beats(input int n);
        for (int k = 0; k < 1000 && beat_cnt < n; k++) @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v, input string tag);
        int n;
        logic [31:0] fs, fd;
        n  = (int'(v.blk) + 1) * (int'(v.xfer) + 1);
        set_cfg(v, 1'b1);
        pulse_start();
        if (v.mode inside {3'd2, 3'd3, 3'd4}) hw_req = 1; else sw_trig = 1;
        wait_idle(150000);
        hw_req = 0; sw_trig = 0;
        fs = (v.srl || v.sfix) ? SRC0 : SRC0 + 32'(n * exp_inc);
        fd = (v.drl || v.dfix) ? DST0 : DST0 + 32'(n * exp_inc);
        chk(beat_cnt == n, "R4", {tag, " beat total"}, 64'(beat_cnt), 64'(n));
        chk(bad_beats == 0, "R2/R3", {tag, " beat address/size"}, 64'(bad_beats), 0);
        chk(mem_src == fs, "R9", {tag, " final source"}, 64'(mem_src), 64'(fs));
        chk(mem_dst == fd, "R9", {tag, " final destination"}, 64'(mem_dst), 64'(fd));
        chk(done_flag == v.den, "R10", {tag, " done flag"}, 64'(done_flag), 64'(v.den));
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !done_flag && !err_flag, "R1", "state in reset",
            {busy, mem_req, done_flag, err_flag}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !mem_req && !done_flag && !err_flag, "R1", "state after reset",
            {busy, mem_req, done_flag, err_flag}, 0);

        // Table walk (R2 R3 R4 R6 R9 R10)
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], $sformatf("vec%0d", i));
        end

        // R6/R4: 65536 blocks of one byte in a single burst
        v = '{3'd1, 2'd0, 4'd0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
        run_vec(v, "max blocks R6");

        // R5: software block mode pauses between blocks; R10 start clears done
        v = '{3'd0, 2'd2, 4'd2, 16'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
        set_cfg(v, 1'b1);
        pulse_start();
        chk(done_flag == 0, "R10", "done cleared by start", 64'(done_flag), 0);
        @(negedge clk) sw_trig = 1;
        @(negedge clk) sw_trig = 0;
        repeat (8) @(negedge clk);
        chk(beat_cnt == 3, "R5", "beats after one trigger", 64'(beat_cnt), 3);
        chk(busy && !mem_req, "R5", "waiting between blocks", {busy, mem_req}, 2'b10);
        @(negedge clk) sw_trig = 1;
        @(negedge clk) sw_trig = 0;
        wait_idle(50);
        chk(beat_cnt == 6 && done_flag, "R5", "second block finishes job",
            64'(beat_cnt), 6);

        // R8: sw_trig ignored in a hardware mode
        v = '{3'd3, 2'd0, 4'd0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
        set_cfg(v, 1'b1);
        pulse_start();
        @(negedge clk) sw_trig = 1;
        @(negedge clk) sw_trig = 0;
        repeat (5) @(negedge clk);
        chk(beat_cnt == 0 && busy, "R8", "sw_trig in hardware mode", 64'(beat_cnt), 0);
        @(negedge clk) hw_req = 1;
        @(negedge clk) hw_req = 0;
        wait_idle(20);
        chk(beat_cnt == 1 && !busy, "R8", "hw_req starts hardware block", 64'(beat_cnt), 1);

        // R7: demand mode stops when the request falls
        v = '{3'd2, 2'd2, 4'd3, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
        set_cfg(v, 1'b1);
        pulse_start();
        hw_req = 1;
        wait_beats(1);
        hw_req = 0;
        repeat (5) @(negedge clk);
        chk(beat_cnt == 2 && busy && !mem_req, "R7", "demand pause", 64'(beat_cnt), 2);
        hw_req = 1;
        wait_idle(30);
        hw_req = 0;
        chk(beat_cnt == 4 && bad_beats == 0 && done_flag, "R7", "demand resume in place",
            64'(beat_cnt), 4);

        // R11: error response mid-burst
        v = '{3'd1, 2'd2, 4'd0, 16'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
        set_cfg(v, 1'b1);
        pulse_start();
        sw_trig = 1;
        wait_beats(3);
        err_on = 1;
        wait_idle(20);
        err_on = 0; sw_trig = 0;
        chk(beat_cnt == 3, "R11", "beats before error", 64'(beat_cnt), 3);
        chk(err_flag && !done_flag && !busy, "R11", "error flags",
            {err_flag, done_flag, busy}, 3'b100);

        // R11: forced stop while armed, error reporting disabled
        v = '{3'd0, 2'd0, 4'd1, 16'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
        set_cfg(v, 1'b0);
        pulse_start();
        @(negedge clk) force_stop = 1;
        @(negedge clk) force_stop = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !err_flag && !done_flag && beat_cnt == 0, "R11",
            "stop with reporting off", {busy, err_flag, done_flag}, 0);

        // R11: forced stop mid-burst with reporting on
        v = '{3'd1, 2'd1, 4'd3, 16'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
        set_cfg(v, 1'b1);
        pulse_start();
        sw_trig = 1;
        wait_beats(2);
        force_stop = 1;
        @(negedge clk) force_stop = 0;
        sw_trig = 0;
        wait_idle(10);
        chk(beat_cnt == 2 && err_flag && !done_flag && !busy, "R11", "stop mid-burst",
            64'(beat_cnt), 2);

        // R12: request holds while the port stalls
        v = '{3'd1, 2'd2, 4'd1, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
        set_cfg(v, 1'b1);
        ack_on = 0;
        pulse_start();
        sw_trig = 1;
        @(negedge clk) sw_trig = 0;
        repeat (5) @(negedge clk);
        chk(mem_req && mem_src == SRC0 && mem_dst == DST0, "R12", "stalled request held",
            64'(mem_src), 64'(SRC0));
        ack_on = 1;
        wait_idle(20);
        chk(beat_cnt == 2 && done_flag, "R12", "stall then completion", 64'(beat_cnt), 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule